// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block turns three external interrupt pins into interrupt requests for a CPU. Each pin is first synchronised to the block clock. A 2-bit sense field per pin then decides what counts as an event: a held low level, any change, a falling edge or a rising edge. Edge events are caught in sticky per-pin flags. A low-level request follows the synchronised pin directly and never sets a flag.

Software reaches the block through a small register port with a 2-bit address. The port holds the sense-control register, a per-pin enable mask and a flag register. Each flag bit is cleared by writing a 1 to it. The interrupt controller can also clear a flag with a per-pin acknowledge pulse. A request reaches the CPU only when the global interrupt enable and the pin's mask bit are both set. Because the pins are sampled wherever their level comes from, a pin driven by the device's own output raises an interrupt like any other, which lets software raise an interrupt itself.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, the sense register, the mask register, the flag register and all requests are zero, and every synchroniser stage holds 1 (pins are treated as idle high).
- R2: The register map is as follows. Address 0 is the sense register. Pin i's field sits at bits 2i+1:2i, and bits 7:6 always read 0. Address 1 is the mask, in bits 2:0, with the other bits reading 0. Address 2 is the flag register, in bits 2:0. Address 3 reads 0.
- R3: Sense code 01 sets the pin's flag on any change, 10 on a falling edge and 11 on a rising edge. The flag becomes visible after the third rising clock edge that follows the pin change, and not before.
- R4: With sense code 00, the request for a pin is high while its synchronised level is low. This holds from the second rising clock edge after the pin falls until the second edge after it rises. This mode never sets the flag.
- R5: A pin's request is high only when the global enable and that pin's mask bit are both 1. Either one dropping removes the request in the same cycle.
- R6: Writing a 1 to a bit at address 2 clears that flag. Writing a 0 leaves the flag unchanged.
- R7: A one-cycle acknowledge pulse on a pin clears that pin's flag. It has no effect on a low-level request.
- R8: If a new edge event and a clear (flag write or acknowledge) fall in the same cycle for one pin, the flag ends set.
- R9: In the cycle in which a register write changes a pin's sense field, no event is recorded for that pin. A write that leaves the field unchanged does not suppress events.
- R10: An edge that does not match the selected edge mode leaves the flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low reset |
| regAddr | input | 2 | Register address |
| regWrEn | input | 1 | Write strobe for the addressed register |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data of the addressed register (combinational) |
| pinIn | input | 3 | External interrupt pins |
| globalIe | input | 1 | Global interrupt enable |
| ackIn | input | 3 | Per-pin acknowledge pulses from the interrupt controller |
| irqReq | output | 3 | Per-pin interrupt requests |

## Verification
Two things can act on the same sticky flag in one cycle: an edge event arriving from the synchroniser, and a clear from either a write-one-to-clear or an acknowledge. The bench changes a pin, waits exactly two clock edges so that the edge is pending, and then issues the clear so that it lands on the same clock edge. It judges the result by reading the flag back, which must still be 1. The same pending-edge alignment is used with a sense-field write, where the flag must instead stay 0, and with an unchanged field, where the flag must be set.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 2;
  localparam int SENSE_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_SENSE = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MASK  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_FLAG  = 2'd2;

  typedef enum logic [SENSE_W-1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  typedef struct packed {
    logic             wrSense;
    logic             wrMask;
    logic             wrFlag;
    logic [REG_W-1:0] data;
  } regStrobe_t;
endpackage

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int NUM_IN = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [ADDR_W-1:0]           regAddr,
  input  logic                        regWrEn,
  input  logic [REG_W-1:0]            regWrData,
  input  logic [NUM_IN-1:0]           flagQ,
  output regStrobe_t                  strobe,
  output logic [NUM_IN*SENSE_W-1:0]   senseQ,
  output logic [NUM_IN-1:0]           maskQ,
  output logic [REG_W-1:0]            regRdData
);
  localparam int SENSE_BITS = NUM_IN * SENSE_W;

  always_comb begin
    strobe.wrSense = regWrEn && (regAddr == ADDR_SENSE);
    strobe.wrMask  = regWrEn && (regAddr == ADDR_MASK);
    strobe.wrFlag  = regWrEn && (regAddr == ADDR_FLAG);
    strobe.data    = regWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      senseQ <= '0;
      maskQ  <= '0;
    end else begin
      if (strobe.wrSense) senseQ <= regWrData[SENSE_BITS-1:0];
      if (strobe.wrMask)  maskQ  <= regWrData[NUM_IN-1:0];
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_SENSE: regRdData[SENSE_BITS-1:0] = senseQ;
      ADDR_MASK:  regRdData[NUM_IN-1:0]     = maskQ;
      ADDR_FLAG:  regRdData[NUM_IN-1:0]     = flagQ;
      default:    regRdData = '0;
    endcase
  end
endmodule

// File: rtl/ext_irq_datapath.sv
module ext_irq_datapath
  import ext_irq_pkg::*;
#(
  parameter int NUM_IN      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_IN-1:0]         pinIn,
  input  regStrobe_t                strobe,
  input  logic [NUM_IN*SENSE_W-1:0] senseQ,
  input  logic [NUM_IN-1:0]         maskQ,
  input  logic                      globalIe,
  input  logic [NUM_IN-1:0]         ackIn,
  output logic [NUM_IN-1:0]         flagQ,
  output logic [NUM_IN-1:0]         evtHit,
  output logic [NUM_IN-1:0]         irqReq
);
  localparam int SENSE_BITS = NUM_IN * SENSE_W;

  logic unusedBits;
  assign unusedBits = ^{strobe.wrMask, strobe.data[REG_W-1:SENSE_BITS]};

  for (genvar i = 0; i < NUM_IN; i++) begin : g_pin
    logic [SYNC_STAGES-1:0] syncChain;
    logic                   syncPin;
    logic                   prevPin;
    logic                   riseSeen;
    logic                   fallSeen;
    logic                   modeHit;
    logic                   senseChange;
    logic                   clrReq;
    sense_e                 mode;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncChain <= '1;
        prevPin   <= 1'b1;
      end else begin
        syncChain <= {syncChain[SYNC_STAGES-2:0], pinIn[i]};
        prevPin   <= syncPin;
      end
    end

    assign syncPin  = syncChain[SYNC_STAGES-1];
    assign riseSeen = syncPin & ~prevPin;
    assign fallSeen = ~syncPin & prevPin;
    assign mode     = sense_e'(senseQ[SENSE_W*i +: SENSE_W]);

    always_comb begin
      case (mode)
        SENSE_ANY:  modeHit = riseSeen | fallSeen;
        SENSE_FALL: modeHit = fallSeen;
        SENSE_RISE: modeHit = riseSeen;
        default:    modeHit = 1'b0;
      endcase
    end

    assign senseChange = strobe.wrSense &&
                         (strobe.data[SENSE_W*i +: SENSE_W] != senseQ[SENSE_W*i +: SENSE_W]);
    assign evtHit[i]   = modeHit & ~senseChange;
    assign clrReq      = (strobe.wrFlag & strobe.data[i]) | ackIn[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          flagQ[i] <= 1'b0;
      else if (evtHit[i]) flagQ[i] <= 1'b1;
      else if (clrReq)    flagQ[i] <= 1'b0;
    end

    assign irqReq[i] = globalIe & maskQ[i] &
                       ((mode == SENSE_LOW) ? ~syncPin : flagQ[i]);
  end
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_irq_pkg::*;
#(
  parameter int NUM_IN      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWrEn,
  input  logic [REG_W-1:0]    regWrData,
  output logic [REG_W-1:0]    regRdData,
  input  logic [NUM_IN-1:0]   pinIn,
  input  logic                globalIe,
  input  logic [NUM_IN-1:0]   ackIn,
  output logic [NUM_IN-1:0]   irqReq
);
  regStrobe_t                strobe;
  logic [NUM_IN*SENSE_W-1:0] senseQ;
  logic [NUM_IN-1:0]         maskQ;
  logic [NUM_IN-1:0]         flagQ;
  logic [NUM_IN-1:0]         evtHit;

  ext_irq_ctrl #(.NUM_IN(NUM_IN)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .flagQ     (flagQ),
    .strobe    (strobe),
    .senseQ    (senseQ),
    .maskQ     (maskQ),
    .regRdData (regRdData)
  );

  ext_irq_datapath #(.NUM_IN(NUM_IN), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .pinIn    (pinIn),
    .strobe   (strobe),
    .senseQ   (senseQ),
    .maskQ    (maskQ),
    .globalIe (globalIe),
    .ackIn    (ackIn),
    .flagQ    (flagQ),
    .evtHit   (evtHit),
    .irqReq   (irqReq)
  );
endmodule

// File: rtl/ext_irq_sense_chk.sv
module ext_irq_sense_chk
  import ext_irq_pkg::*;
#(
  parameter int NUM_IN = 3
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      globalIe,
  input logic [NUM_IN-1:0]         ackIn,
  input logic [NUM_IN-1:0]         irqReq,
  input logic [ADDR_W-1:0]         regAddr,
  input logic [REG_W-1:0]          regRdData,
  input logic [NUM_IN*SENSE_W-1:0] senseQ,
  input logic [NUM_IN-1:0]         maskQ,
  input logic [NUM_IN-1:0]         flagQ,
  input logic [NUM_IN-1:0]         evtHit
);
  localparam int SENSE_BITS = NUM_IN * SENSE_W;

  p_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    !globalIe |-> (irqReq == '0));

  p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_SENSE) |-> ((regRdData >> SENSE_BITS) == '0));

  for (genvar i = 0; i < NUM_IN; i++) begin : g_chk
    p_mask_r5: assert property (@(posedge clk) disable iff (!rstN)
      !maskQ[i] |-> !irqReq[i]);

    p_flag_src_r3: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flagQ[i]) |-> $past(evtHit[i]));

    p_level_noevt_r4: assert property (@(posedge clk) disable iff (!rstN)
      (senseQ[SENSE_W*i +: SENSE_W] == 2'b00) |-> !evtHit[i]);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
      evtHit[i] |=> flagQ[i]);

    p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
      (ackIn[i] && !evtHit[i]) |=> !flagQ[i]);
  end
endmodule

bind ext_irq_sense ext_irq_sense_chk #(.NUM_IN(NUM_IN)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .globalIe  (globalIe),
  .ackIn     (ackIn),
  .irqReq    (irqReq),
  .regAddr   (regAddr),
  .regRdData (regRdData),
  .senseQ    (senseQ),
  .maskQ     (maskQ),
  .flagQ     (flagQ),
  .evtHit    (evtHit)
);

// File: tb/ext_irq_sense_bench.sv
module ext_irq_sense_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [2:0] pinIn = 3'b111;
  logic       globalIe = 1'b0;
  logic [2:0] ackIn = '0;
  logic [2:0] irqReq;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  ext_irq_sense u_ext_irq_sense (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .pinIn(pinIn),
    .globalIe(globalIe), .ackIn(ackIn), .irqReq(irqReq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    regRead(2'd0, v); chk("R1 sense", v, 8'h00);
    regRead(2'd1, v); chk("R1 mask", v, 8'h00);
    regRead(2'd2, v); chk("R1 flags", v, 8'h00);
    chk("R1 irq", {5'd0, irqReq}, 8'h00);
  endtask

  task automatic t_regmap();
    logic [7:0] v;
    regWrite(2'd0, 8'hFF); regRead(2'd0, v); chk("R2 sense reserved", v, 8'h3F);
    regWrite(2'd0, 8'h1B); regRead(2'd0, v); chk("R2 sense fields", v, 8'h1B);
    regWrite(2'd1, 8'hFF); regRead(2'd1, v); chk("R2 mask", v, 8'h07);
    regRead(2'd3, v); chk("R2 addr3", v, 8'h00);
    regWrite(2'd1, 8'h00);
    regWrite(2'd0, 8'h00);
  endtask

  task automatic t_edges();
    logic [7:0] v;
    regWrite(2'd0, 8'h1E);   // pin0 fall, pin1 rise, pin2 any
    regWrite(2'd1, 8'h07);
    globalIe = 1'b1;
    pinIn = 3'b000;
    cycles(2);
    regRead(2'd2, v); chk("R3 latency", v, 8'h00);
    cycles(1);
    regRead(2'd2, v); chk("R3 fall/any, R10 rise ignores fall", v, 8'h05);
    chk("R3 irq", {5'd0, irqReq}, 8'h05);
    regWrite(2'd2, 8'h02);
    regRead(2'd2, v); chk("R6 write zero keeps", v, 8'h05);
    regWrite(2'd2, 8'h07);
    regRead(2'd2, v); chk("R6 w1c", v, 8'h00);
    pinIn = 3'b111;
    cycles(3);
    regRead(2'd2, v); chk("R3 rise/any, R10 fall ignores rise", v, 8'h06);
    regWrite(2'd2, 8'h07);
  endtask

  task automatic t_level();
    logic [7:0] v;
    regWrite(2'd0, 8'h00);
    regWrite(2'd1, 8'h01);
    pinIn[0] = 1'b0;
    cycles(1);
    chk("R4 not yet", {5'd0, irqReq}, 8'h00);
    cycles(1);
    chk("R4 level req", {5'd0, irqReq}, 8'h01);
    regRead(2'd2, v); chk("R4 no flag", v, 8'h00);
    ackIn = 3'b001; cycles(1); ackIn = '0;
    chk("R7 ack no effect on level", {5'd0, irqReq}, 8'h01);
    pinIn[0] = 1'b1;
    cycles(2);
    chk("R4 release", {5'd0, irqReq}, 8'h00);
  endtask

  task automatic t_gate();
    regWrite(2'd1, 8'h01);
    pinIn[0] = 1'b0;
    cycles(2);
    globalIe = 1'b0; #1;
    chk("R5 global off", {5'd0, irqReq}, 8'h00);
    globalIe = 1'b1; #1;
    chk("R5 global on", {5'd0, irqReq}, 8'h01);
    regWrite(2'd1, 8'h00);
    chk("R5 mask off", {5'd0, irqReq}, 8'h00);
    pinIn[0] = 1'b1;
    cycles(2);
  endtask

  task automatic t_ack();
    logic [7:0] v;
    regWrite(2'd0, 8'h0C);
    regWrite(2'd1, 8'h02);
    pinIn[1] = 1'b0; cycles(3);
    pinIn[1] = 1'b1; cycles(3);
    regRead(2'd2, v); chk("R3 rise flag", v, 8'h02);
    chk("R5 irq via flag", {5'd0, irqReq}, 8'h02);
    ackIn = 3'b010; cycles(1); ackIn = '0;
    regRead(2'd2, v); chk("R7 ack clears", v, 8'h00);
  endtask

  task automatic t_setwins();
    logic [7:0] v;
    regWrite(2'd0, 8'h04);   // pin1 any
    pinIn[1] = 1'b0; cycles(3);
    regRead(2'd2, v); chk("R3 any fall", v, 8'h02);
    pinIn[1] = 1'b1; cycles(2);
    regWrite(2'd2, 8'h02);
    regRead(2'd2, v); chk("R8 event beats w1c", v, 8'h02);
    pinIn[1] = 1'b0; cycles(2);
    ackIn = 3'b010; cycles(1); ackIn = '0;
    regRead(2'd2, v); chk("R8 event beats ack", v, 8'h02);
    regWrite(2'd2, 8'h07);
    pinIn[1] = 1'b1; cycles(3);
    regWrite(2'd2, 8'h07);
  endtask

  task automatic t_sensechg();
    logic [7:0] v;
    regWrite(2'd0, 8'h01);   // pin0 any
    pinIn[0] = 1'b0; cycles(2);
    regWrite(2'd0, 8'h02);   // pin0 -> fall in the edge cycle
    regRead(2'd2, v); chk("R9 change suppresses", v, 8'h00);
    pinIn[0] = 1'b1; cycles(3);
    regRead(2'd2, v); chk("R10 fall mode ignores rise", v, 8'h00);
    pinIn[0] = 1'b0; cycles(2);
    regWrite(2'd0, 8'h02);   // same field value
    regRead(2'd2, v); chk("R9 same value keeps event", v, 8'h01);
  endtask

  initial begin
    cycles(3);
    rstN = 1'b1;
    cycles(1);
    t_reset();
    t_regmap();
    t_edges();
    t_level();
    t_gate();
    t_ack();
    t_setwins();
    t_sensechg();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #4000000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule